// File: doc/BRIEF.md
# Interlaced Field Sync Sequencer

This block sits behind a sync-pulse measurement stage in a 625-line interlaced video capture path. Each incoming record is one classified sync pulse: its kind (line sync, equalising or broad) and the time since the pulse before it, in microseconds. The block follows the vertical blanking pattern: a run of equalising pulses at half-line spacing, a run of broad pulses at half-line spacing, and a second equalising run. It then watches the horizontal syncs of the picture area.

From this pattern the block raises a one-cycle strobe at the start of every field. It also works out which of the two interlaced fields has begun, from the gap between the last equalising pulse and the first line sync: about half a line means the first field, about a full line means the second. Within the picture area it strobes each line sync and keeps a line index. A lock flag shows that a whole vertical pattern has been followed.

If any pulse does not fit the pattern, the block drops lock and goes back to hunting for an equalising pulse.

Top module: `field_sync_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `field_start`, `line_start`, `field_id`, `locked` and `line_count` are all zero after that edge, and the sequencer is searching.
- R2: A gap matches a nominal spacing when it lies within nominal ± `TOL` inclusive (default 4). For example, 60 and 68 both match the 64 us line spacing, and 69 does not.
- R3: `field_start` is high for exactly one cycle, in the cycle after a broad pulse (`pulse_kind` = 2). That broad pulse must have a gap of about 56 us and must follow exactly `RUN_LEN` equalising pulses (`pulse_kind` = 1), each after the first spaced half a line apart. `field_id` inverts together with this strobe.
- R4: The first line sync (`pulse_kind` = 0) after `RUN_LEN` post-broad equalising pulses sets `field_id` to 0 if its gap is about 34 us, and to 1 if its gap is about 64 us.
- R5: That first line sync raises `line_start` for one cycle and sets `line_count` to 0. Each later line sync with a full-line gap raises `line_start` and adds one to `line_count`.
- R6: `locked` rises together with the first `line_start` of a field. It stays high through the next vertical interval while every pulse fits the pattern.
- R7: A pulse that does not fit the pattern clears `locked` and returns the block to searching. While searching, only an equalising pulse has any effect, so line syncs produce no `line_start`.
- R8: In the picture area, an equalising pulse with a full-line gap ends the picture area and counts as the first pulse of the next pre-broad run. `locked` stays high.
- R9: The broad run must hold exactly `RUN_LEN` pulses, and the first equalising pulse after it must come about 7 us after the last broad pulse. A short pre-broad run or a short broad run drops lock.
- R10: `line_count` saturates at its all-ones value and does not wrap.
- R11: Kind code 3 is reserved and always counts as out of sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_valid | input | 1 | One-cycle qualifier for a pulse record |
| pulse_kind | input | 2 | 0 line sync, 1 equalising, 2 broad, 3 reserved |
| pulse_gap | input | GAP_W | Time since the previous pulse, in microseconds |
| field_start | output | 1 | One-cycle strobe at the start of a field |
| field_id | output | 1 | 0 first field, 1 second field |
| line_start | output | 1 | One-cycle strobe per picture-area line sync |
| line_count | output | LINE_W | Line index within the picture area |
| locked | output | 1 | A full vertical pattern has been followed |

## Verification
The bench builds the block with `LINE_W` set to 4 and keeps every timing parameter at its default. This lets about twenty line syncs drive the counter into saturation. The default tolerance of 4 puts the inclusive window edges at 60 and 68 and the first reject at 69, which are the values the bench drives. Two full interlaced fields, one of each parity, run back to back so that the hand-over from the picture area into the next vertical interval is exercised while locked.

// File: rtl/fss_pkg.sv
// Shared types for the field sync sequencer.
// Assumes: pulse kinds arrive already classified by an upstream stage.
package fss_pkg;

    typedef enum logic [1:0] {
        PK_HSYNC = 2'd0,
        PK_EQ    = 2'd1,
        PK_BROAD = 2'd2,
        PK_RSVD  = 2'd3
    } pulse_kind_e;

    typedef enum logic [2:0] {
        ST_SEARCH,
        ST_PRE_EQ,
        ST_BROAD,
        ST_POST_EQ,
        ST_ACTIVE
    } seq_state_e;

    // Index of each spacing window in the gap match vector.
    localparam int GC_HALF  = 0;
    localparam int GC_FULL  = 1;
    localparam int GC_ENTRY = 2;
    localparam int GC_HSCAN = 3;
    localparam int GC_SHORT = 4;
    localparam int GC_NUM   = 5;

endpackage

// File: rtl/fss_gap_window.sv
// Bank of window comparators: one match bit for each nominal pulse spacing.
// Assumes: the gap is an unsigned count of microseconds, and each nominal
// value plus TOL fits in GAP_W+1 bits.
module fss_gap_window
    import fss_pkg::*;
#(
    parameter int GAP_W     = 8,
    parameter int TOL       = 4,
    parameter int HALF_LINE = 32,
    parameter int FULL_LINE = 64,
    parameter int ENTRY_GAP = 56,
    parameter int HALF_SCAN = 34,
    parameter int SHORT_GAP = 7
) (
    input  logic [GAP_W-1:0]  gap,
    output logic [GC_NUM-1:0] hit
);

    localparam int NOMINAL [GC_NUM] = '{HALF_LINE, FULL_LINE, ENTRY_GAP, HALF_SCAN, SHORT_GAP};

    logic [GAP_W:0] gap_x;
    assign gap_x = {1'b0, gap};

    // One inclusive window comparator per nominal spacing.
    for (genvar g = 0; g < GC_NUM; g++) begin : g_win
        localparam int LO = (NOMINAL[g] > TOL) ? NOMINAL[g] - TOL : 0;
        localparam int HI = NOMINAL[g] + TOL;
        localparam logic [GAP_W:0] LO_V = (GAP_W+1)'(LO);
        localparam logic [GAP_W:0] HI_V = (GAP_W+1)'(HI);
        assign hit[g] = (gap_x >= LO_V) && (gap_x <= HI_V);
    end

endmodule

// File: rtl/fss_seq_fsm.sv
// Vertical-interval sequencer: walks the pre-equalising, broad and
// post-equalising runs, then follows the picture area line by line.
// Assumes: at most one pulse record per cycle, with the gap already
// matched against the spacing windows.
module fss_seq_fsm
    import fss_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_valid,
    input  pulse_kind_e       pulse_kind,
    input  logic [GC_NUM-1:0] hit,
    output logic              field_start,
    output logic              field_id,
    output logic              line_start,
    output logic              locked,
    output logic              line_clr,
    output logic              line_inc
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] RUN_ONE  = CNT_W'(1);

    seq_state_e       state, nxt_state;
    logic [CNT_W-1:0] run_cnt, nxt_cnt;
    logic             go_field, go_first, go_line, first_f2, drop;
    logic             run_open, run_done;

    assign run_open = (run_cnt < RUN_FULL);
    assign run_done = (run_cnt == RUN_FULL);

    // Next-state decision for one pulse record.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = run_cnt;
        go_field  = 1'b0;
        go_first  = 1'b0;
        go_line   = 1'b0;
        first_f2  = 1'b0;
        drop      = 1'b0;
        if (pulse_valid) begin
            case (state)
                ST_SEARCH: begin
                    if (pulse_kind == PK_EQ) begin
                        nxt_state = ST_PRE_EQ;
                        nxt_cnt   = RUN_ONE;
                    end
                end
                ST_PRE_EQ: begin
                    if (pulse_kind == PK_EQ && hit[GC_HALF] && run_open) begin
                        nxt_cnt = run_cnt + 1'b1;
                    end else if (pulse_kind == PK_BROAD && hit[GC_ENTRY] && run_done) begin
                        nxt_state = ST_BROAD;
                        nxt_cnt   = RUN_ONE;
                        go_field  = 1'b1;
                    end else begin
                        drop = 1'b1;
                    end
                end
                ST_BROAD: begin
                    if (pulse_kind == PK_BROAD && hit[GC_HALF] && run_open) begin
                        nxt_cnt = run_cnt + 1'b1;
                    end else if (pulse_kind == PK_EQ && hit[GC_SHORT] && run_done) begin
                        nxt_state = ST_POST_EQ;
                        nxt_cnt   = RUN_ONE;
                    end else begin
                        drop = 1'b1;
                    end
                end
                ST_POST_EQ: begin
                    if (pulse_kind == PK_EQ && hit[GC_HALF] && run_open) begin
                        nxt_cnt = run_cnt + 1'b1;
                    end else if (pulse_kind == PK_HSYNC && run_done && hit[GC_HSCAN]) begin
                        nxt_state = ST_ACTIVE;
                        go_first  = 1'b1;
                    end else if (pulse_kind == PK_HSYNC && run_done && hit[GC_FULL]) begin
                        nxt_state = ST_ACTIVE;
                        go_first  = 1'b1;
                        first_f2  = 1'b1;
                    end else begin
                        drop = 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (pulse_kind == PK_HSYNC && hit[GC_FULL]) begin
                        go_line = 1'b1;
                    end else if (pulse_kind == PK_EQ && hit[GC_FULL]) begin
                        nxt_state = ST_PRE_EQ;
                        nxt_cnt   = RUN_ONE;
                    end else begin
                        drop = 1'b1;
                    end
                end
                default: drop = 1'b1;
            endcase
        end
        if (drop) begin
            nxt_state = ST_SEARCH;
            nxt_cnt   = '0;
        end
    end

    assign line_clr = go_first;
    assign line_inc = go_line;

    // State, run counter, strobes, field identity and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_SEARCH;
            run_cnt     <= '0;
            field_start <= 1'b0;
            line_start  <= 1'b0;
            field_id    <= 1'b0;
            locked      <= 1'b0;
        end else begin
            state       <= nxt_state;
            run_cnt     <= nxt_cnt;
            field_start <= go_field;
            line_start  <= go_first | go_line;
            if (go_field) begin
                field_id <= ~field_id;
            end else if (go_first) begin
                field_id <= first_f2;
            end
            if (drop) begin
                locked <= 1'b0;
            end else if (go_first) begin
                locked <= 1'b1;
            end
        end
    end

    AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !field_start);  // R3
    AST_FS_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> $past(pulse_valid));  // R3
    AST_LOCK_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> line_start);  // R6
    AST_LINE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> locked);  // R5
    AST_RSVD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_valid && pulse_kind == PK_RSVD) |=> !locked);  // R11

endmodule

// File: rtl/fss_line_counter.sv
// Saturating picture-area line index.
// Assumes: a clear and an increment never come in the same cycle; if they
// do, the clear wins.
module fss_line_counter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [LINE_W-1:0] count
);

    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    // Clear on the first line, otherwise count up and hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_LINE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && inc && !clr) |=> count == CNT_MAX);  // R10
    AST_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);  // R5

endmodule

// File: rtl/field_sync_sequencer.sv
// Top level: tracks the interlaced vertical interval from classified sync
// pulses and produces field and line timing.
// Assumes: pulse_gap is in microseconds and is measured between the
// leading edges of consecutive sync pulses.
module field_sync_sequencer
    import fss_pkg::*;
#(
    parameter int GAP_W     = 8,
    parameter int LINE_W    = 10,
    parameter int RUN_LEN   = 5,
    parameter int TOL       = 4,
    parameter int HALF_LINE = 32,
    parameter int FULL_LINE = 64,
    parameter int ENTRY_GAP = 56,
    parameter int HALF_SCAN = 34,
    parameter int SHORT_GAP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_valid,
    input  logic [1:0]        pulse_kind,
    input  logic [GAP_W-1:0]  pulse_gap,
    output logic              field_start,
    output logic              field_id,
    output logic              line_start,
    output logic [LINE_W-1:0] line_count,
    output logic              locked
);

    logic [GC_NUM-1:0] gap_hit;
    logic              line_clr, line_inc;

    fss_gap_window #(
        .GAP_W     (GAP_W),
        .TOL       (TOL),
        .HALF_LINE (HALF_LINE),
        .FULL_LINE (FULL_LINE),
        .ENTRY_GAP (ENTRY_GAP),
        .HALF_SCAN (HALF_SCAN),
        .SHORT_GAP (SHORT_GAP)
    ) u_win (
        .gap (pulse_gap),
        .hit (gap_hit)
    );

    fss_seq_fsm #(
        .RUN_LEN (RUN_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_valid (pulse_valid),
        .pulse_kind  (pulse_kind_e'(pulse_kind)),
        .hit         (gap_hit),
        .field_start (field_start),
        .field_id    (field_id),
        .line_start  (line_start),
        .locked      (locked),
        .line_clr    (line_clr),
        .line_inc    (line_inc)
    );

    fss_line_counter #(
        .LINE_W (LINE_W)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (line_clr),
        .inc   (line_inc),
        .count (line_count)
    );

endmodule

// File: tb/sim_field_sync_sequencer.sv
// Bench: a table of pulses with the expected outputs, then directed cases.
module sim_field_sync_sequencer;

    localparam int LW = 4;
    localparam logic [1:0] H = 2'd0, E = 2'd1, B = 2'd2, X = 2'd3;

    typedef struct packed {
        logic [1:0]    kind;
        logic [7:0]    gap;
        logic          fs;
        logic          fid;
        logic          ls;
        logic [LW-1:0] lc;
        logic          lk;
    } vec_t;

    // Two fields: the first of each parity, with lock held across the hand-over (R8).
    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{E, 8'd100, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{E, 8'd32,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{E, 8'd31,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{E, 8'd32,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{E, 8'd31,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{B, 8'd56,  1'b1, 1'b1, 1'b0, 4'd0, 1'b0},
        '{B, 8'd32,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{B, 8'd31,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{B, 8'd32,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{B, 8'd31,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{E, 8'd7,   1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{E, 8'd32,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{E, 8'd31,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{E, 8'd32,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{E, 8'd31,  1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{H, 8'd34,  1'b0, 1'b0, 1'b1, 4'd0, 1'b1},
        '{H, 8'd63,  1'b0, 1'b0, 1'b1, 4'd1, 1'b1},
        '{H, 8'd64,  1'b0, 1'b0, 1'b1, 4'd2, 1'b1},
        '{H, 8'd65,  1'b0, 1'b0, 1'b1, 4'd3, 1'b1},
        '{E, 8'd61,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{E, 8'd32,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{E, 8'd31,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{E, 8'd32,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{E, 8'd31,  1'b0, 1'b0, 1'b0, 4'd3, 1'b1},
        '{B, 8'd56,  1'b1, 1'b1, 1'b0, 4'd3, 1'b1},
        '{B, 8'd32,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{B, 8'd31,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{B, 8'd32,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{B, 8'd31,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{E, 8'd7,   1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{E, 8'd32,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{E, 8'd31,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{E, 8'd32,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{E, 8'd31,  1'b0, 1'b1, 1'b0, 4'd3, 1'b1},
        '{H, 8'd64,  1'b0, 1'b1, 1'b1, 4'd0, 1'b1},
        '{H, 8'd64,  1'b0, 1'b1, 1'b1, 4'd1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pulse_valid;
    logic [1:0]    pulse_kind;
    logic [7:0]    pulse_gap;
    logic          field_start, field_id, line_start, locked;
    logic [LW-1:0] line_count;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    field_sync_sequencer #(.LINE_W(LW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pulse_valid (pulse_valid),
        .pulse_kind  (pulse_kind),
        .pulse_gap   (pulse_gap),
        .field_start (field_start),
        .field_id    (field_id),
        .line_start  (line_start),
        .line_count  (line_count),
        .locked      (locked)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one pulse record at a falling edge; return at the next falling edge.
    task automatic send(input logic [1:0] k, input logic [7:0] g);
        pulse_valid = 1'b1;
        pulse_kind  = k;
        pulse_gap   = g;
        @(negedge clk);
        pulse_valid = 1'b0;
    endtask

    // Full vertical pattern from searching, with run lengths and final gap chosen.
    task automatic vertical(input int n_pre, input int n_broad, input logic [7:0] last_gap);
        send(E, 8'd100);
        for (int i = 1; i < n_pre; i++) send(E, 8'd32);
        send(B, 8'd56);
        for (int i = 1; i < n_broad; i++) send(B, 8'd32);
        send(E, 8'd7);
        for (int i = 1; i < 5; i++) send(E, 8'd32);
        send(H, last_gap);
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        $display("FAIL watchdog: actual 0 expected 1 completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        pulse_valid = 1'b0;
        pulse_kind  = 2'd0;
        pulse_gap   = 8'd0;
        repeat (3) @(negedge clk);
        // R1: everything idle under reset
        chk("R1", "field_start", int'(field_start), 0);
        chk("R1", "line_start", int'(line_start), 0);
        chk("R1", "field_id", int'(field_id), 0);
        chk("R1", "locked", int'(locked), 0);
        chk("R1", "line_count", int'(line_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over two interlaced fields.
        for (int v = 0; v < NV; v++) begin
            send(TBL[v].kind, TBL[v].gap);
            chk("R3", $sformatf("field_start v%0d", v), int'(field_start), int'(TBL[v].fs));
            chk("R4", $sformatf("field_id v%0d", v), int'(field_id), int'(TBL[v].fid));
            chk("R5", $sformatf("line_start v%0d", v), int'(line_start), int'(TBL[v].ls));
            chk("R5", $sformatf("line_count v%0d", v), int'(line_count), int'(TBL[v].lc));
            chk("R6", $sformatf("locked v%0d", v), int'(locked), int'(TBL[v].lk));
        end
        // R3: the strobe is gone one idle cycle later
        @(negedge clk);
        chk("R3", "line_start after idle", int'(line_start), 0);

        // R2: window edges on the full-line spacing
        send(H, 8'd68);
        chk("R2", "count at 68", int'(line_count), 2);
        chk("R2", "strobe at 68", int'(line_start), 1);
        send(H, 8'd60);
        chk("R2", "count at 60", int'(line_count), 3);
        send(H, 8'd69);
        chk("R2", "lock after 69", int'(locked), 0);
        chk("R7", "no strobe after 69", int'(line_start), 0);
        chk("R7", "count held", int'(line_count), 3);
        // R7: line syncs ignored while searching
        send(H, 8'd64);
        chk("R7", "search ignores hsync", int'(line_start), 0);
        chk("R7", "search stays unlocked", int'(locked), 0);

        // R9: short pre-broad run gives no field start
        send(E, 8'd100);
        for (int i = 0; i < 3; i++) send(E, 8'd32);
        send(B, 8'd56);
        chk("R9", "short pre run field_start", int'(field_start), 0);
        chk("R9", "short pre run locked", int'(locked), 0);

        // R9: short broad run, then the pattern cannot complete
        vertical(5, 4, 8'd34);
        chk("R9", "short broad run line_start", int'(line_start), 0);
        chk("R9", "short broad run locked", int'(locked), 0);

        // R10: saturation of the line index
        vertical(5, 5, 8'd34);
        chk("R4", "field 1 from half gap", int'(field_id), 0);
        chk("R6", "locked after field", int'(locked), 1);
        for (int i = 0; i < 15; i++) send(H, 8'd64);
        chk("R10", "count at top", int'(line_count), 15);
        send(H, 8'd64);
        send(H, 8'd64);
        chk("R10", "count holds", int'(line_count), 15);
        chk("R10", "strobe still fires", int'(line_start), 1);

        // R11: reserved kind drops lock
        send(X, 8'd64);
        chk("R11", "reserved drops lock", int'(locked), 0);
        chk("R11", "reserved no strobe", int'(line_start), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule